// File: doc/BRIEF.md
# ATA Task-File Command Sequencer

This block executes one pass-through ATA command descriptor at a time on a simple task-file register bus. A descriptor carries an action byte, an eight-bit register mask, seven task-file byte values, a transfer length, and the default device bit assigned to the logical unit. The action byte decides whether the block first waits for the device to drop BSY. It also decides whether device selection comes before or after the register and command writes, where the DEV bit comes from, and whether device and phase errors end the data phase. Instead of issuing a command, the action byte can request a fixed eight-byte snapshot of the task file.

Every access on the bus is a request held until a one-cycle acknowledge. After the command writes, the block reads the status register once. It then opens a data-phase window for downstream transfer logic and ends each descriptor with a one-cycle done pulse carrying a result code. The UDMA and IDENTIFY action bits are not interpreted here. They are presented as mode flags for the data-path logic.

Top module: `ata_tf_sequencer`

## Requirements
- R1: A descriptor with action bit 0 set is invalid if the length is not 8, or if action bit 3 or bit 4 is also set. The block then ends with done code 4 (invalid) and makes no bus access.
- R2: With action bit 2 clear, the first accesses are reads of bus address 8 (alternate status), repeated until a read returns bit 7 (BSY) clear. With bit 2 set, no alternate-status poll comes first.
- R3: If BSY is still set on a poll response after `poll_limit` cycles of polling, the descriptor ends with done code 3 (timeout) and no write is made.
- R4: In command mode with action bit 1 clear, writes go to bus addresses 6, 1, 2, 3, 4, 5, 7 in that order. With bit 1 set, the order is 1, 2, 3, 4, 5, 7, 6.
- R5: A register at bus address k (1..7) is written only when mask bit k is set, and it gets byte k-1 of `desc_tf`. Address 7 is the command register.
- R6: In the byte written to address 6, bit 4 is `lun_dev` when action bit 5 is clear, and bit 4 of the descriptor's address-6 byte when action bit 5 is set.
- R7: With action bit 0 set, the block makes no writes. It emits exactly 8 bytes on `rd_data`, in slot order 0..7: alternate status (address 8) first, then addresses 1..7. A slot whose mask bit is clear is not read and returns 0x00. The descriptor ends with done code 0.
- R8: After the command writes, address 7 is read once. If bit 0 (ERR) is set and action bit 4 is clear, the descriptor ends with done code 1 and no data phase. If action bit 4 is set, the data phase still opens.
- R9: During the data phase (`xfer_en` high), `xfer_perr` ends the descriptor with done code 2 when action bit 3 is clear. When bit 3 is set, `xfer_perr` is ignored and `xfer_done` ends the descriptor with done code 0.
- R10: `mode_udma` and `mode_ident` follow action bits 6 and 7 of the last accepted descriptor.
- R11: `desc_ready` is high only while idle, and no bus request is made then. Each descriptor produces exactly one one-cycle `done` pulse.
- R12: While `bus_req` is high without `bus_ack`, the request, address, direction and write data stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Idle, descriptor accepted |
| desc_action | input | 8 | Action byte |
| desc_mask | input | 8 | Register mask, bit k for slot/address k |
| desc_tf | input | 56 | Task-file bytes, byte k-1 for address k |
| desc_len | input | LEN_W | Requested transfer length |
| lun_dev | input | 1 | Default DEV bit of the logical unit |
| poll_limit | input | TMO_W | BSY poll timeout in cycles |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 4 | 1..7 command block, 8 alternate status |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with ack |
| bus_ack | input | 1 | Access complete |
| xfer_en | output | 1 | Data phase open |
| xfer_done | input | 1 | Data phase finished |
| xfer_perr | input | 1 | Phase error seen by data path |
| rd_valid | output | 1 | Snapshot byte valid |
| rd_data | output | 8 | Snapshot byte |
| done | output | 1 | Descriptor finished, one cycle |
| done_code | output | 3 | 0 ok, 1 device error, 2 phase error, 3 timeout, 4 invalid |
| mode_udma | output | 1 | UDMA data-phase flag |
| mode_ident | output | 1 | IDENTIFY data flag |

## Verification
A table of command descriptors covers four things: both device-selection orders, sparse and full masks, a command-only mask, and a mask with no command bit. Comparing the logged write address sequences separates the two orderings and shows that masking skips registers rather than reordering them. The same rows pair `lun_dev` against the descriptor's DEV bit with action bit 5 both ways, which exposes a swapped DEV source.

Directed descriptors cover the remaining paths. A busy count of three distinguishes a poll loop from a single poll, and a device that never clears BSY separates the timeout path. A sparse snapshot mask over non-zero register contents shows zero-fill rather than pass-through. ERR in status and an injected phase error are each applied with the matching override bit both clear and set.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

   typedef enum logic [2:0] {
      CODE_OK        = 3'd0,
      CODE_DEV_ERR   = 3'd1,
      CODE_PHASE_ERR = 3'd2,
      CODE_TIMEOUT   = 3'd3,
      CODE_INVALID   = 3'd4
   } done_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_STEP,
      ST_ACCESS,
      ST_STATUS,
      ST_DATA
   } seq_state_e;

   localparam int unsigned TF_SLOTS     = 8;
   localparam logic [3:0]  ALT_ADDR     = 4'h8;
   localparam logic [3:0]  CMD_ADDR     = 4'h7;
   localparam logic [3:0]  DEVHEAD_ADDR = 4'h6;

   localparam int unsigned ACT_SNAP      = 0;
   localparam int unsigned ACT_LATE_SEL  = 1;
   localparam int unsigned ACT_NO_POLL   = 2;
   localparam int unsigned ACT_PERR_CONT = 3;
   localparam int unsigned ACT_DERR_CONT = 4;
   localparam int unsigned ACT_DEV_DESC  = 5;
   localparam int unsigned ACT_UDMA      = 6;
   localparam int unsigned ACT_IDENT     = 7;

endpackage

// File: rtl/tfs_step_map.sv
module tfs_step_map
   import tfs_pkg::*;
(
   input  logic       late_sel,
   input  logic [2:0] step,
   output logic [3:0] reg_addr
);

   localparam int unsigned N = TF_SLOTS;

   logic [3:0] early_tab [N];
   logic [3:0] late_tab  [N];

   // early: dev/head, then 1..5, then command
   // late : 1..5, then command, then dev/head
   for (genvar g = 0; g < N; g++) begin : g_tab
      if (g == 0) begin : g_e_dev
         assign early_tab[g] = DEVHEAD_ADDR;
      end else if (g <= N - 3) begin : g_e_plain
         assign early_tab[g] = 4'(g);
      end else if (g == N - 2) begin : g_e_cmd
         assign early_tab[g] = CMD_ADDR;
      end else begin : g_e_end
         assign early_tab[g] = 4'h0;
      end

      if (g <= N - 4) begin : g_l_plain
         assign late_tab[g] = 4'(g + 1);
      end else if (g == N - 3) begin : g_l_cmd
         assign late_tab[g] = CMD_ADDR;
      end else if (g == N - 2) begin : g_l_dev
         assign late_tab[g] = DEVHEAD_ADDR;
      end else begin : g_l_end
         assign late_tab[g] = 4'h0;
      end
   end

   assign reg_addr = late_sel ? late_tab[step] : early_tab[step];

endmodule

// File: rtl/tfs_poll_timer.sv
module tfs_poll_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   if (CNT_W < 2) begin : g_bad_w
      $error("tfs_poll_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q >= limit);

   // once expired, the timer stays expired for as long as polling continues
   assert_timer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && expired) |=> (!run || expired));

endmodule

// File: rtl/ata_tf_sequencer.sv
module ata_tf_sequencer
   import tfs_pkg::*;
#(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             desc_valid,
   output logic             desc_ready,
   input  logic [7:0]       desc_action,
   input  logic [7:0]       desc_mask,
   input  logic [55:0]      desc_tf,
   input  logic [LEN_W-1:0] desc_len,
   input  logic             lun_dev,
   input  logic [TMO_W-1:0] poll_limit,
   output logic             bus_req,
   output logic             bus_we,
   output logic [3:0]       bus_addr,
   output logic [7:0]       bus_wdata,
   input  logic [7:0]       bus_rdata,
   input  logic             bus_ack,
   output logic             xfer_en,
   input  logic             xfer_done,
   input  logic             xfer_perr,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [2:0]       done_code,
   output logic             mode_udma,
   output logic             mode_ident
);

   localparam int unsigned SNAP_LEN  = TF_SLOTS;
   localparam int unsigned WR_STEPS  = TF_SLOTS - 1;
   localparam int unsigned STEP_W    = $clog2(TF_SLOTS) + 1;
   localparam int unsigned SLOT_W    = $clog2(TF_SLOTS);

   if (LEN_W < STEP_W) begin : g_bad_len
      $error("ata_tf_sequencer: LEN_W too small to hold the snapshot length");
   end
   if (TMO_W < 2) begin : g_bad_tmo
      $error("ata_tf_sequencer: TMO_W must be at least 2");
   end

   seq_state_e        state_q;
   logic [7:0]        act_q;
   logic [7:0]        mask_q;
   logic [63:0]       tf_pad_q;
   logic              lun_q;
   logic [STEP_W-1:0] step_q;
   logic [3:0]        acc_addr_q;
   logic              acc_we_q;
   logic [7:0]        acc_wdata_q;
   logic              rd_valid_q;
   logic [7:0]        rd_data_q;
   logic              done_q;
   logic [2:0]        code_q;

   logic              snap;
   logic              desc_bad;
   logic              accept;
   logic [3:0]        map_addr;
   logic              tmo_expired;
   logic [SLOT_W-1:0] slot_idx;
   logic              slot_on;
   logic [7:0]        tf_byte;
   logic              dev_bit;
   logic [7:0]        wr_byte;

   assign snap     = act_q[ACT_SNAP];
   assign accept   = (state_q == ST_IDLE) && desc_valid;
   assign desc_bad = desc_action[ACT_SNAP] &&
                     ((desc_len != LEN_W'(SNAP_LEN)) ||
                      desc_action[ACT_PERR_CONT] || desc_action[ACT_DERR_CONT]);

   tfs_step_map u_map (
      .late_sel (act_q[ACT_LATE_SEL]),
      .step     (step_q[SLOT_W-1:0]),
      .reg_addr (map_addr)
   );

   tfs_poll_timer #(.CNT_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_POLL),
      .limit   (poll_limit),
      .expired (tmo_expired)
   );

   assign slot_idx = snap ? step_q[SLOT_W-1:0] : map_addr[SLOT_W-1:0];
   assign slot_on  = mask_q[slot_idx];
   assign tf_byte  = tf_pad_q[{slot_idx, 3'b000} +: 8];
   assign dev_bit  = act_q[ACT_DEV_DESC] ? tf_pad_q[8*DEVHEAD_ADDR + 4] : lun_q;
   assign wr_byte  = (map_addr == DEVHEAD_ADDR) ? {tf_byte[7:5], dev_bit, tf_byte[3:0]}
                                                : tf_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         act_q       <= '0;
         mask_q      <= '0;
         tf_pad_q    <= '0;
         lun_q       <= 1'b0;
         step_q      <= '0;
         acc_addr_q  <= '0;
         acc_we_q    <= 1'b0;
         acc_wdata_q <= '0;
         rd_valid_q  <= 1'b0;
         rd_data_q   <= '0;
         done_q      <= 1'b0;
         code_q      <= CODE_OK;
      end else begin
         rd_valid_q <= 1'b0;
         done_q     <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (desc_valid) begin
                  act_q    <= desc_action;
                  mask_q   <= desc_mask;
                  tf_pad_q <= {desc_tf, 8'h00};
                  lun_q    <= lun_dev;
                  step_q   <= '0;
                  if (desc_bad) begin
                     done_q <= 1'b1;
                     code_q <= CODE_INVALID;
                  end else if (desc_action[ACT_NO_POLL]) begin
                     state_q <= ST_STEP;
                  end else begin
                     state_q <= ST_POLL;
                  end
               end
            end
            ST_POLL: begin
               if (bus_ack) begin
                  if (!bus_rdata[7]) begin
                     state_q <= ST_STEP;
                  end else if (tmo_expired) begin
                     done_q  <= 1'b1;
                     code_q  <= CODE_TIMEOUT;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_STEP: begin
               if (snap) begin
                  if (step_q == STEP_W'(SNAP_LEN)) begin
                     done_q  <= 1'b1;
                     code_q  <= CODE_OK;
                     state_q <= ST_IDLE;
                  end else if (slot_on) begin
                     acc_addr_q <= (step_q == '0) ? ALT_ADDR : {1'b0, step_q[SLOT_W-1:0]};
                     acc_we_q   <= 1'b0;
                     state_q    <= ST_ACCESS;
                  end else begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= 8'h00;
                     step_q     <= step_q + 1'b1;
                  end
               end else begin
                  if (step_q == STEP_W'(WR_STEPS)) begin
                     state_q <= ST_STATUS;
                  end else if (slot_on) begin
                     acc_addr_q  <= map_addr;
                     acc_we_q    <= 1'b1;
                     acc_wdata_q <= wr_byte;
                     state_q     <= ST_ACCESS;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_ACCESS: begin
               if (bus_ack) begin
                  if (!acc_we_q) begin
                     rd_valid_q <= 1'b1;
                     rd_data_q  <= bus_rdata;
                  end
                  step_q  <= step_q + 1'b1;
                  state_q <= ST_STEP;
               end
            end
            ST_STATUS: begin
               if (bus_ack) begin
                  if (bus_rdata[0] && !act_q[ACT_DERR_CONT]) begin
                     done_q  <= 1'b1;
                     code_q  <= CODE_DEV_ERR;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (xfer_perr && !act_q[ACT_PERR_CONT]) begin
                  done_q  <= 1'b1;
                  code_q  <= CODE_PHASE_ERR;
                  state_q <= ST_IDLE;
               end else if (xfer_done) begin
                  done_q  <= 1'b1;
                  code_q  <= CODE_OK;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign desc_ready = (state_q == ST_IDLE);
   assign bus_req    = (state_q == ST_POLL) || (state_q == ST_ACCESS) || (state_q == ST_STATUS);
   assign bus_we     = (state_q == ST_ACCESS) && acc_we_q;
   assign bus_addr   = (state_q == ST_POLL)   ? ALT_ADDR :
                       (state_q == ST_STATUS) ? CMD_ADDR : acc_addr_q;
   assign bus_wdata  = bus_we ? acc_wdata_q : 8'h00;
   assign xfer_en    = (state_q == ST_DATA);
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign done       = done_q;
   assign done_code  = code_q;
   assign mode_udma  = act_q[ACT_UDMA];
   assign mode_ident = act_q[ACT_IDENT];

   // ---------------- checks ----------------
   logic touched_q;
   logic wrote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         touched_q <= 1'b0;
         wrote_q   <= 1'b0;
      end else if (accept) begin
         touched_q <= 1'b0;
         wrote_q   <= 1'b0;
      end else begin
         if (bus_req)           touched_q <= 1'b1;
         if (bus_req && bus_we) wrote_q   <= 1'b1;
      end
   end

   assert_invalid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code == CODE_INVALID) |-> !touched_q);

   assert_timeout_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code == CODE_TIMEOUT) |-> !wrote_q);

   assert_snap_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!desc_ready && snap) |-> !bus_we);

   assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready |-> (!bus_req && !xfer_en));

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));

endmodule

// File: tb/sim_ata_tf_sequencer.sv
`timescale 1ns/1ps
module sim_ata_tf_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        desc_valid = 1'b0;
   logic        desc_ready;
   logic [7:0]  desc_action = '0;
   logic [7:0]  desc_mask = '0;
   logic [55:0] desc_tf = '0;
   logic [15:0] desc_len = '0;
   logic        lun_dev = 1'b0;
   logic [15:0] poll_limit = 16'd1000;
   logic        bus_req, bus_we;
   logic [3:0]  bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        bus_ack;
   logic        xfer_en;
   logic        xfer_done, xfer_perr;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        done;
   logic [2:0]  done_code;
   logic        mode_udma, mode_ident;

   ata_tf_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_action(desc_action), .desc_mask(desc_mask), .desc_tf(desc_tf),
      .desc_len(desc_len), .lun_dev(lun_dev), .poll_limit(poll_limit),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .xfer_en(xfer_en),
      .xfer_done(xfer_done), .xfer_perr(xfer_perr), .rd_valid(rd_valid),
      .rd_data(rd_data), .done(done), .done_code(done_code),
      .mode_udma(mode_udma), .mode_ident(mode_ident)
   );

   // ---------------- device and data-path model ----------------
   logic        clr_log = 1'b1;
   int          busy_reads = 0;
   logic        busy_forever = 1'b0;
   logic        perr_mode = 1'b0;
   logic [7:0]  alt_val = 8'h50;
   logic [7:0]  status_val = 8'h50;
   logic [7:0]  mem [8];

   logic [31:0] wseq;
   int          n_wr, n_acc, n_alt, n_snap, n_done, rdy_bad, wd_bad, xcnt;
   logic [7:0]  wdev;
   logic [3:0]  first_addr;
   logic        xfer_seen;
   logic [7:0]  snap_log [8];

   function automatic logic [7:0] exp_byte(input logic [3:0] a);
      return (a == 4'h7) ? 8'hEC : 8'(8'h11 * {4'h0, a});
   endfunction

   assign xfer_perr = xfer_en && perr_mode && (xcnt == 2);
   assign xfer_done = xfer_en && (xcnt == 4);

   always @(posedge clk) begin
      if (clr_log) begin
         bus_ack <= 1'b0; bus_rdata <= 8'h00; wseq <= '0; wdev <= '0;
         n_wr <= 0; n_acc <= 0; n_alt <= 0; n_snap <= 0; n_done <= 0;
         rdy_bad <= 0; wd_bad <= 0; xcnt <= 0; first_addr <= 4'hF; xfer_seen <= 1'b0;
         for (int i = 0; i < 8; i++) snap_log[i] <= 8'hEE;
      end else begin
         bus_ack <= 1'b0;
         xcnt    <= xfer_en ? xcnt + 1 : 0;
         if (xfer_en) xfer_seen <= 1'b1;
         if (done) n_done <= n_done + 1;
         if (bus_req && desc_ready) rdy_bad <= rdy_bad + 1;
         if (rd_valid) begin
            if (n_snap < 8) snap_log[n_snap[2:0]] <= rd_data;
            n_snap <= n_snap + 1;
         end
         if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (n_acc == 0) first_addr <= bus_addr;
            n_acc <= n_acc + 1;
            if (bus_we) begin
               wseq <= wseq | (32'(bus_addr) << (4 * n_wr));
               n_wr <= n_wr + 1;
               if (bus_addr == 4'h6) wdev <= bus_wdata;
               else if (bus_wdata != exp_byte(bus_addr)) wd_bad <= wd_bad + 1;
            end else if (bus_addr == 4'h8) begin
               bus_rdata <= (busy_forever || n_alt < busy_reads) ? 8'h80 : alt_val;
               n_alt <= n_alt + 1;
            end else if (bus_addr == 4'h7) begin
               bus_rdata <= status_val;
            end else begin
               bus_rdata <= mem[bus_addr[2:0]];
            end
         end
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_desc(input logic [7:0] act, input logic [7:0] mask,
                           input logic [7:0] devb, input logic lun, input logic [15:0] len,
                           output logic [2:0] code, output logic got);
      @(negedge clk); clr_log = 1'b1;
      @(negedge clk); clr_log = 1'b0;
      desc_action = act; desc_mask = mask; lun_dev = lun; desc_len = len;
      desc_tf = {8'hEC, devb, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
      desc_valid = 1'b1;
      @(negedge clk); desc_valid = 1'b0;
      got = 1'b0; code = 3'h7;
      for (int i = 0; i < 3000 && !got; i++) begin
         if (done) begin got = 1'b1; code = done_code; end
         else @(negedge clk);
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   // action, mask, lun, devbyte, expected write sequence, count, expected dev/head write
   localparam int VN = 5;
   localparam logic [63:0] VEC [VN] = '{
      {8'h04, 8'hFE, 1'b1, 8'hA0, 28'h7543216, 3'd7, 8'hB0},
      {8'h06, 8'hFE, 1'b0, 8'hB0, 28'h6754321, 3'd7, 8'hA0},
      {8'h24, 8'hC2, 1'b0, 8'hB0, 28'h0000716, 3'd3, 8'hB0},
      {8'h26, 8'h80, 1'b1, 8'hA0, 28'h0000007, 3'd1, 8'h00},
      {8'h24, 8'h7E, 1'b1, 8'hA0, 28'h0543216, 3'd6, 8'hA0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] code;
      logic       got;
      for (int i = 0; i < 8; i++) mem[i] = 8'h70 + 8'(i);
      mem[2] = 8'h5A; mem[5] = 8'hC3;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset ready", {63'd0, desc_ready}, 64'd1);
      chk("R11 reset req", {63'd0, bus_req}, 64'd0);
      chk("R11 reset done", {63'd0, done}, 64'd0);

      // table of command descriptors: R4 R5 R6 (no poll: R2)
      for (int v = 0; v < VN; v++) begin
         run_desc(VEC[v][63:56], VEC[v][55:48], VEC[v][46:39], VEC[v][47], 16'd0, code, got);
         chk("R11 done seen", {63'd0, got}, 64'd1);
         chk("R4 done code", {61'd0, code}, 64'd0);
         chk("R4 write order", {32'd0, wseq}, {36'd0, VEC[v][38:11]});
         chk("R5 write count", 64'(n_wr), {61'd0, VEC[v][10:8]});
         chk("R5 write data", 64'(wd_bad), 64'd0);
         chk("R6 dev/head byte", {56'd0, wdev}, {56'd0, VEC[v][7:0]});
         chk("R2 no poll", 64'(n_alt), 64'd0);
         chk("R11 single done", 64'(n_done), 64'd1);
         chk("R11 quiet ready", 64'(rdy_bad), 64'd0);
      end

      // R2 poll loop
      busy_reads = 3;
      run_desc(8'h00, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R2 poll first access", {60'd0, first_addr}, 64'h8);
      chk("R2 poll read count", 64'(n_alt), 64'd4);
      chk("R2 command after poll", {32'd0, wseq}, 64'h7);
      chk("R2 done code", {61'd0, code}, 64'd0);
      busy_reads = 0;

      // R3 timeout
      busy_forever = 1'b1; poll_limit = 16'd20;
      run_desc(8'h00, 8'hFE, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R3 timeout code", {61'd0, code}, 64'd3);
      chk("R3 no writes", 64'(n_wr), 64'd0);
      busy_forever = 1'b0; poll_limit = 16'd1000;

      // R1 invalid combinations
      run_desc(8'h05, 8'hFF, 8'hA0, 1'b0, 16'd7, code, got);
      chk("R1 bad length code", {61'd0, code}, 64'd4);
      chk("R1 bad length no access", 64'(n_acc), 64'd0);
      run_desc(8'h15, 8'hFF, 8'hA0, 1'b0, 16'd8, code, got);
      chk("R1 derr+snap code", {61'd0, code}, 64'd4);
      run_desc(8'h0D, 8'hFF, 8'hA0, 1'b0, 16'd8, code, got);
      chk("R1 perr+snap code", {61'd0, code}, 64'd4);
      chk("R1 perr+snap no access", 64'(n_acc), 64'd0);

      // R7 snapshot with sparse mask
      status_val = 8'h58;
      run_desc(8'h05, 8'hA5, 8'hA0, 1'b0, 16'd8, code, got);
      chk("R7 snapshot code", {61'd0, code}, 64'd0);
      chk("R7 snapshot count", 64'(n_snap), 64'd8);
      chk("R7 snapshot no write", 64'(n_wr), 64'd0);
      chk("R7 snapshot bytes",
          {snap_log[0], snap_log[1], snap_log[2], snap_log[3],
           snap_log[4], snap_log[5], snap_log[6], snap_log[7]},
          {8'h50, 8'h00, 8'h5A, 8'h00, 8'h00, 8'hC3, 8'h00, 8'h58});
      status_val = 8'h50;

      // R8 device error
      status_val = 8'h51;
      run_desc(8'h04, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R8 halt code", {61'd0, code}, 64'd1);
      chk("R8 no data phase", {63'd0, xfer_seen}, 64'd0);
      run_desc(8'h14, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R8 override code", {61'd0, code}, 64'd0);
      chk("R8 override data phase", {63'd0, xfer_seen}, 64'd1);
      status_val = 8'h50;

      // R9 phase error
      perr_mode = 1'b1;
      run_desc(8'h04, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R9 halt code", {61'd0, code}, 64'd2);
      run_desc(8'h0C, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R9 override code", {61'd0, code}, 64'd0);
      perr_mode = 1'b0;

      // R10 mode flags
      run_desc(8'hC4, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R10 flags set", {62'd0, mode_udma, mode_ident}, 64'd3);
      run_desc(8'h44, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R10 udma only", {62'd0, mode_udma, mode_ident}, 64'd2);
      run_desc(8'h04, 8'h80, 8'hA0, 1'b0, 16'd0, code, got);
      chk("R10 flags clear", {62'd0, mode_udma, mode_ident}, 64'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule